// File: doc/BRIEF.md
# Two-Dimensional Product Code Encoder

This block turns a rectangular array of data bits into a product codeword. Each incoming data row is 4 bits wide. It is first protected by an extended Hamming (8,4) code. The block then XOR-accumulates each encoded row into an 8-bit column-parity register. After `ROWS` data rows, that register is emitted as one extra row, so every output column becomes a single-parity codeword.

The column parity also covers the row-parity bits, so the last row holds the cross-parity corner: the column code applied to the row parity. Because both codes are linear and systematic, the parity row is itself a valid row codeword. The minimum distance of the array is 4 × 2 = 8.

Data rows enter one per handshake on a valid/ready stream. Each encoded row leaves through a single output register one cycle after it is accepted. The parity row follows the last data row and carries the last flag. With the default `ROWS` = 4, the output array is 8 columns by 5 rows.

Top module: `prod_enc`

## Requirements
- R1: While reset is high, out_valid is 0 at the next clock edge and in_ready is 1.
- R2: A data row d accepted at a clock edge appears on out_data one cycle later, with out_valid = 1 and out_last = 0. Bits [3:0] of that row equal d. Bits [7:4] hold the parity {p3,p2,p1,p0}, where p0 = d0^d1^d3, p1 = d0^d2^d3, p2 = d1^d2^d3, and p3 is the XOR of d[3:0] and p0..p2.
- R3: Every beat on the output, data or parity, is a row codeword. Its four Hamming checks are zero, and its 8 bits have even weight.
- R4: After every `ROWS` accepted data rows, exactly one parity row follows. It is the bitwise XOR of those `ROWS` encoded rows. out_last is 1 on that beat and 0 on all others.
- R5: Once the final data row of an array has been accepted, in_ready stays 0 until the parity row is in the output register.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values into the next cycle.
- R7: The column parity starts from zero for each array. The parity row of any array depends only on that array's data rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data row offered |
| in_ready | output | 1 | Block can take a data row this cycle |
| in_data | input | 4 | Data row bits |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Consumer takes the output row |
| out_data | output | 8 | Encoded row, data in [3:0], row parity in [7:4] |
| out_last | output | 1 | Marks the parity row that ends an array |

## Verification
Each accepted data row is due in the output register exactly one cycle after its accepting edge. The bench therefore checks the bits of that row at the following sample, whatever out_ready does. A parity row has no fixed latency, since it waits for a free output slot. The bench instead predicts the beat order and compares each beat when it is handed off, so stalls do not matter. Inputs are driven at the falling edge. All signals are read 1 ns later, which is before the next rising edge that acts on them. A back-pressured beat is therefore compared against itself one cycle later, and in_ready is checked on every cycle of the parity window.

// File: rtl/prod_enc_pkg.sv
package prod_enc_pkg;

    localparam int ROW_DATA_W = 4;
    localparam int ROW_CODE_W = 8;
    localparam int ROW_PAR_W  = ROW_CODE_W - ROW_DATA_W;

    typedef logic [ROW_DATA_W-1:0] row_data_t;
    typedef logic [ROW_CODE_W-1:0] row_code_t;
    typedef logic [ROW_PAR_W-1:0]  row_chk_t;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_PAR  = 1'b1
    } phase_e;

    typedef struct packed {
        logic      last;
        row_code_t bits;
    } out_beat_t;

    // Systematic extended Hamming (8,4): data low, parity high.
    function automatic row_code_t hamm_encode(input row_data_t d);
        row_chk_t p;
        p[0] = d[0] ^ d[1] ^ d[3];
        p[1] = d[0] ^ d[2] ^ d[3];
        p[2] = d[1] ^ d[2] ^ d[3];
        p[3] = ^d ^ p[0] ^ p[1] ^ p[2];
        return {p, d};
    endfunction

    // All-zero result means the row is a codeword.
    function automatic row_chk_t hamm_syndrome(input row_code_t c);
        row_chk_t s;
        s[0] = c[4] ^ c[0] ^ c[1] ^ c[3];
        s[1] = c[5] ^ c[0] ^ c[2] ^ c[3];
        s[2] = c[6] ^ c[1] ^ c[2] ^ c[3];
        s[3] = ^c;
        return s;
    endfunction

endpackage

// File: rtl/prod_row_enc.sv
module prod_row_enc
    import prod_enc_pkg::*;
(
    input  row_data_t data_i,
    output row_code_t code_o
);
    always_comb begin
        code_o = hamm_encode(data_i);
    end

    always_comb begin
        assert_rowcode_R3: assert (hamm_syndrome(code_o) == '0);
    end
endmodule

// File: rtl/prod_col_acc.sv
module prod_col_acc
    import prod_enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      add_en,
    input  row_code_t add_row,
    input  logic      clr,
    output row_code_t acc_o
);
    row_code_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= acc_q ^ add_row;
        end
    end

    assign acc_o = acc_q;

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        !(clr && add_en));
endmodule

// File: rtl/prod_seq.sv
module prod_seq
    import prod_enc_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   row_fire,
    input  logic   par_fire,
    output phase_e phase_o,
    output logic   final_row_o
);
    localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROWS - 1);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_q;

    assign final_row_o = (cnt_q == LAST_IDX);
    assign phase_o     = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
        end else begin
            if (row_fire) begin
                if (final_row_o) begin
                    cnt_q   <= '0;
                    phase_q <= PH_PAR;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (par_fire) begin
                phase_q <= PH_DATA;
            end
        end
    end

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_IDX);

    assert_par_cnt_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PAR) |-> (cnt_q == '0));
endmodule

// File: rtl/prod_enc.sv
module prod_enc
    import prod_enc_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [ROW_DATA_W-1:0] in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ROW_CODE_W-1:0] out_data,
    output logic                  out_last
);
    row_code_t enc_row;
    row_code_t col_par;
    phase_e    phase;
    logic      final_row;
    logic      slot_free;
    logic      row_fire;
    logic      par_fire;
    out_beat_t beat_q;
    logic      valid_q;

    assign slot_free = !valid_q || out_ready;
    assign in_ready  = (phase == PH_DATA) && slot_free;
    assign row_fire  = in_valid && in_ready;
    assign par_fire  = (phase == PH_PAR) && slot_free;

    prod_row_enc u_row (
        .data_i (in_data),
        .code_o (enc_row)
    );

    prod_col_acc u_col (
        .clk     (clk),
        .rst     (rst),
        .add_en  (row_fire),
        .add_row (enc_row),
        .clr     (par_fire),
        .acc_o   (col_par)
    );

    prod_seq #(.ROWS(ROWS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .row_fire    (row_fire),
        .par_fire    (par_fire),
        .phase_o     (phase),
        .final_row_o (final_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (row_fire) begin
            valid_q <= 1'b1;
            beat_q  <= '{last: 1'b0, bits: enc_row};
        end else if (par_fire) begin
            valid_q <= 1'b1;
            beat_q  <= '{last: 1'b1, bits: col_par};
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = beat_q.bits;
    assign out_last  = beat_q.last;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_codeword_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (hamm_syndrome(out_data) == '0));

    assert_parity_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (row_fire && final_row) |=> !in_ready);

    assert_one_last_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !(out_valid && out_last));

    assert_data_beat_R2: assert property (@(posedge clk) disable iff (rst)
        row_fire |=> (out_valid && !out_last && out_data[ROW_DATA_W-1:0] == $past(in_data)));
endmodule

// File: tb/sim_prod_enc.sv
`timescale 1ns/1ps
module sim_prod_enc;
    localparam int ROWS = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [3:0] in_data;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_last;

    always #2.5 clk = ~clk;

    prod_enc #(.ROWS(ROWS)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [8:0] exp_q[$];
    logic [7:0] m_acc = '0;
    int         m_cnt = 0;
    bit         par_pend = 0;
    int         arrays_out = 0;
    bit         prev_in = 0;
    logic [7:0] prev_row;
    bit         hold = 0;
    logic [8:0] hold_beat;

    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic p0, p1, p2, p3;
        p0 = d[0] ^ d[1] ^ d[3];
        p1 = d[0] ^ d[2] ^ d[3];
        p2 = d[1] ^ d[2] ^ d[3];
        p3 = d[0] ^ d[1] ^ d[2] ^ d[3] ^ p0 ^ p1 ^ p2;
        return {p3, p2, p1, p0, d};
    endfunction

    function automatic bit ref_is_code(input logic [7:0] c);
        return ((c[4] ^ c[0] ^ c[1] ^ c[3]) == 1'b0) &&
               ((c[5] ^ c[0] ^ c[2] ^ c[3]) == 1'b0) &&
               ((c[6] ^ c[1] ^ c[2] ^ c[3]) == 1'b0) &&
               ((^c) == 1'b0);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input logic [3:0] d, input bit r);
        logic [8:0] e;
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        out_ready = r;
        #1;
        if (prev_in)
            check(out_valid && !out_last && out_data == prev_row, "R2",
                  {out_valid, out_last, out_data}, {2'b10, prev_row});
        if (hold)
            check(out_valid && {out_last, out_data} == hold_beat, "R6",
                  {out_valid, out_last, out_data}, {1'b1, hold_beat});
        if (par_pend && out_valid && out_last) par_pend = 0;
        if (par_pend) check(!in_ready, "R5", in_ready, 0);
        hold = 0;
        if (out_valid) begin
            check(ref_is_code(out_data), "R3", out_data, 0);
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4", {out_last, out_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({out_last, out_data} == e,
                          (e[8] && arrays_out > 0) ? "R7" : "R4",
                          {out_last, out_data}, e);
                    if (e[8]) arrays_out++;
                end
            end else begin
                hold = 1;
                hold_beat = {out_last, out_data};
            end
        end
        prev_in = 0;
        if (in_valid && in_ready) begin
            prev_in  = 1;
            prev_row = ref_enc(in_data);
            exp_q.push_back({1'b0, prev_row});
            m_acc ^= prev_row;
            m_cnt++;
            if (m_cnt == ROWS) begin
                exp_q.push_back({1'b1, m_acc});
                m_acc = '0;
                m_cnt = 0;
                par_pend = 1;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5a5a));
        rst = 1; in_valid = 0; in_data = '0; out_ready = 0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(!out_valid && in_ready, "R1", {out_valid, in_ready}, 2'b01);
        rst = 0;
        // directed: zeros, ones, walking ones, full speed
        for (int i = 0; i < 4; i++) step(1, 4'h0, 1);
        for (int i = 0; i < 4; i++) step(1, 4'hF, 1);
        for (int i = 0; i < 4; i++) step(1, 4'(1 << i), 1);
        // directed: stall consumer across the parity row
        for (int i = 0; i < 4; i++) step(1, 4'(i * 5 + 3), 0);
        for (int i = 0; i < 3; i++) step(1, 4'h9, 1);
        step(1, 4'h6, 0);
        step(1, 4'h6, 0);
        step(1, 4'h6, 0);
        for (int i = 0; i < 4; i++) step(0, 4'h0, 1);
        // random traffic
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, 4'($urandom), ($urandom % 4) != 0);
        // drain
        for (int i = 0; i < 40; i++) step(0, 4'h0, 1);
        check(exp_q.size() == 0, "R4", exp_q.size(), 0);
        check(arrays_out > 100, "R7", arrays_out, 100);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule